// File: doc/BRIEF.md
# Strided Vector Memory Sequencer

This block drives the memory traffic behind vector load and vector store instructions in a small 16-bit processor with a vector extension. It owns two configuration registers, the element count and the element stride. A move-immediate instruction writes one or the other, depending on a 3-bit selector taken from the instruction. When an operation starts, the sequencer walks the elements in order. For each element it presents one word address on a request/ready memory port. Loads move returned words into the chosen vector register. Stores take words from that register and write them to memory.

The address of element 0 is the base operand plus a 6-bit signed offset scaled to words. Each later address is the previous one plus the stride scaled to words, wrapping modulo 2^16. The count and stride are captured when the operation starts. A one-cycle `done` pulse follows the final accepted element. A zero count finishes at once and makes no memory request.

Top module: `strided_vseq`

## Requirements
- R1: After reset `busy`, `done`, `mem_req` and `vrf_we` are low, and `cfg_len` and `cfg_stride` are 0.
- R2: A configuration write (`cfg_we`) with `cfg_sel`=3'b000 loads `cfg_amt` into the stride register. With `cfg_sel`=3'b001 it loads `cfg_amt` into the length register. The new value is visible on `cfg_stride` or `cfg_len` in the following cycle.
- R3: A configuration write with any other `cfg_sel` value leaves both registers unchanged.
- R4: The first request of an operation has address `op_base + (sign_extend(op_off) << 1)`, taken modulo 2^16.
- R5: Each later request address is the previous address plus `(zero_extend(stride) << 1)`, taken modulo 2^16, using the stride that was captured at start.
- R6: While `mem_req` is high and `mem_ready` is low, the request holds its address, direction and write data into the next cycle.
- R7: On a load, each accepted element i (0 to length-1, in order) raises `vrf_we` in its accept cycle, with `vreg_idx`=i, `vreg_sel` equal to the register given at start, and `vrf_wdata`=`mem_rdata`.
- R8: On a store, `mem_we` is high and `mem_wdata` equals `vrf_rdata` for the element at `vreg_sel`/`vreg_idx`, where the index counts from 0.
- R9: `busy` and `mem_req` rise in the cycle after an accepted start and fall in the cycle after the final accept. `done` pulses for exactly that one cycle. Exactly length elements are accepted.
- R10: A start with length 0 makes no memory request, keeps `busy` low, and pulses `done` in the next cycle.
- R11: A start while `busy` is high is ignored.
- R12: Vector operations never change the configuration registers. A configuration write during an operation does not change that operation's count or stride.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Move-immediate to configuration register |
| cfg_sel | input | 3 | Register selector (000 stride, 001 length) |
| cfg_amt | input | 6 | Unsigned immediate amount |
| op_start | input | 1 | Start a vector memory operation |
| op_store | input | 1 | 1 = store, 0 = load |
| op_vreg | input | 3 | Vector register number |
| op_base | input | 16 | Base address operand |
| op_off | input | 6 | Signed word offset |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Request address |
| mem_wdata | output | 16 | Store data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 16 | Load data, valid with `mem_ready` |
| vreg_sel | output | 3 | Vector register addressed |
| vreg_idx | output | 6 | Element index addressed |
| vrf_we | output | 1 | Vector register element write enable |
| vrf_wdata | output | 16 | Vector register element write data |
| vrf_rdata | input | 16 | Vector register element read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| cfg_len | output | 6 | Current length register |
| cfg_stride | output | 6 | Current stride register |

## Verification
The bench targets negative offsets and a base near the top of the address space, where wrapping matters. A design that zero-extended the offset or truncated the sum would issue requests to the wrong addresses. A maximum stride of 63 catches a design that sign-extended the stride, because its addresses would step backward. Random backpressure shows whether a design advances on a stall or drops the request, and the per-cycle compare would flag either. A zero length, a start while busy, a configuration write in the middle of an operation, and a full 63-element vector probe the count logic. A faulty design would request too many or too few elements, or emit a stray `done`.

// File: rtl/strided_vseq.sv
module strided_vseq #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int LW = 6,
  parameter int OW = 6,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [LW-1:0] cfg_amt,
  input  logic          op_start,
  input  logic          op_store,
  input  logic [RW-1:0] op_vreg,
  input  logic [AW-1:0] op_base,
  input  logic [OW-1:0] op_off,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic [RW-1:0] vreg_sel,
  output logic [LW-1:0] vreg_idx,
  output logic          vrf_we,
  output logic [DW-1:0] vrf_wdata,
  input  logic [DW-1:0] vrf_rdata,
  output logic          busy,
  output logic          done,
  output logic [LW-1:0] cfg_len,
  output logic [LW-1:0] cfg_stride
);
  localparam logic [2:0] SEL_STRIDE = 3'd0;
  localparam logic [2:0] SEL_LEN    = 3'd1;

  logic [LW-1:0] len_r, str_r, run_len, run_str, idx;
  logic [AW-1:0] addr;
  logic [RW-1:0] vr;
  logic          run, st, done_r;

  wire accept = run & mem_ready;
  wire last   = idx == run_len - LW'(1);
  wire [AW-1:0] first_addr = op_base + ({{(AW-OW){op_off[OW-1]}}, op_off} << 1);
  wire [AW-1:0] step       = {{(AW-LW){1'b0}}, run_str} << 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_r <= '0;
      str_r <= '0;
    end else if (cfg_we) begin
      if (cfg_sel == SEL_STRIDE) str_r <= cfg_amt;
      if (cfg_sel == SEL_LEN)    len_r <= cfg_amt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run     <= 1'b0;
      done_r  <= 1'b0;
      st      <= 1'b0;
      vr      <= '0;
      idx     <= '0;
      addr    <= '0;
      run_len <= '0;
      run_str <= '0;
    end else begin
      done_r <= 1'b0;
      if (accept) begin
        if (last) begin
          run    <= 1'b0;
          done_r <= 1'b1;
        end else begin
          idx  <= idx + LW'(1);
          addr <= addr + step;
        end
      end else if (op_start && !run) begin
        if (len_r == '0) begin
          done_r <= 1'b1;
        end else begin
          run     <= 1'b1;
          st      <= op_store;
          vr      <= op_vreg;
          idx     <= '0;
          addr    <= first_addr;
          run_len <= len_r;
          run_str <= str_r;
        end
      end
    end
  end

  assign mem_req    = run;
  assign mem_we     = run & st;
  assign mem_addr   = addr;
  assign mem_wdata  = vrf_rdata;
  assign vreg_sel   = vr;
  assign vreg_idx   = idx;
  assign vrf_we     = accept & ~st;
  assign vrf_wdata  = mem_rdata;
  assign busy       = run;
  assign done       = done_r;
  assign cfg_len    = len_r;
  assign cfg_stride = str_r;
endmodule

module strided_vseq_chk #(
  parameter int AW = 16,
  parameter int LW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic          op_start,
  input logic          busy,
  input logic          done,
  input logic          mem_req,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          vrf_we,
  input logic [LW-1:0] vreg_idx,
  input logic [LW-1:0] cfg_len,
  input logic [LW-1:0] cfg_stride
);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_zero_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    op_start && !busy && cfg_len == '0 |=> done && !busy && !mem_req);

  p_cfg_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_len) && $stable(cfg_stride));

  p_vrf_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vrf_we |-> mem_req && mem_ready && !mem_we);

  p_idx_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mem_ready |=> !busy || vreg_idx == $past(vreg_idx) + LW'(1));
endmodule

bind strided_vseq strided_vseq_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .op_start(op_start),
  .busy(busy), .done(done), .mem_req(mem_req), .mem_ready(mem_ready),
  .mem_we(mem_we), .mem_addr(mem_addr), .vrf_we(vrf_we), .vreg_idx(vreg_idx),
  .cfg_len(cfg_len), .cfg_stride(cfg_stride)
);

// File: tb/strided_vseq_bench.sv
`timescale 1ns/100ps
module strided_vseq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, op_start = 1'b0, op_store = 1'b0, mem_ready = 1'b0;
  logic [2:0] cfg_sel = '0, op_vreg = '0;
  logic [5:0] cfg_amt = '0, op_off = '0;
  logic [15:0] op_base = '0;
  logic mem_req, mem_we, vrf_we, busy, done;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, vrf_wdata, vrf_rdata;
  logic [2:0] vreg_sel;
  logic [5:0] vreg_idx, cfg_len, cfg_stride;

  logic [15:0] vregs [8][64];
  int checks = 0, errors = 0;
  bit always_rdy = 1'b1;
  logic [7:0] lfsr = 8'hA5;
  bit seen_req = 1'b0;

  always #2.5 clk = ~clk;

  assign mem_rdata = mem_addr ^ 16'h5A3C;
  assign vrf_rdata = vregs[vreg_sel][vreg_idx];

  strided_vseq u_strided_vseq (.*);

  always @(posedge clk) if (vrf_we) vregs[vreg_sel][vreg_idx] <= vrf_wdata;

  // reference model
  bit m_busy, m_done, m_store;
  int m_idx, m_addr, m_len, m_str, m_rlen, m_rstr, m_reg;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_store = 0; m_idx = 0; m_addr = 0;
      m_len = 0; m_str = 0; m_rlen = 0; m_rstr = 0; m_reg = 0;
    end else begin
      m_done = 0;
      if (m_busy && mem_ready) begin
        if (m_idx == m_rlen - 1) begin m_busy = 0; m_done = 1; end
        else begin m_idx++; m_addr = (m_addr + 2 * m_rstr) & 16'hFFFF; end
      end else if (op_start && !m_busy) begin
        if (m_len == 0) m_done = 1;
        else begin
          int so;
          so = op_off[5] ? int'(op_off) - 64 : int'(op_off);
          m_busy = 1; m_store = op_store; m_reg = op_vreg; m_idx = 0;
          m_rlen = m_len; m_rstr = m_str;
          m_addr = (int'(op_base) + 2 * so) & 16'hFFFF;
        end
      end
      if (cfg_we && cfg_sel == 3'd0) m_str = cfg_amt;
      if (cfg_we && cfg_sel == 3'd1) m_len = cfg_amt;
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(busy, m_busy, "R9 busy");
    chk(mem_req, m_busy, "R9 mem_req");
    chk(done, m_done, "R9 done");
    chk(cfg_len, m_len, "R2/R12 cfg_len");
    chk(cfg_stride, m_str, "R2/R12 cfg_stride");
    chk(vrf_we, m_busy && !m_store && mem_ready, "R7 vrf_we");
    if (m_busy) begin
      chk(mem_addr, m_addr, m_idx == 0 ? "R4 first address" : "R5 stride address");
      chk(mem_we, m_store, "R8 direction");
      chk(vreg_sel, m_reg, "R7 vreg_sel");
      chk(vreg_idx, m_idx, "R7 element index");
      if (m_store) chk(mem_wdata, vregs[m_reg][m_idx], "R8 store data");
      else if (mem_ready) chk(vrf_wdata, m_addr ^ 16'h5A3C, "R7 load data");
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready = always_rdy | lfsr[0] | lfsr[2];
    if (mem_req && !mem_ready) mem_ready = 1'b0;
    #1;
    if (mem_req) seen_req = 1'b1;
    compare();
    mem_ready = always_rdy | lfsr[0] | lfsr[2];
  endtask

  task automatic cfg(input logic [2:0] s, input logic [5:0] a);
    cfg_we = 1; cfg_sel = s; cfg_amt = a;
    cycle();
    cfg_we = 0;
  endtask

  task automatic run_op(input bit st, input logic [2:0] r, input logic [15:0] b,
                        input logic [5:0] o);
    op_start = 1; op_store = st; op_vreg = r; op_base = b; op_off = o;
    cycle();
    op_start = 0;
    for (int k = 0; k < 400 && (m_busy || m_done); k++) cycle();
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int r = 0; r < 8; r++)
      for (int e = 0; e < 64; e++) vregs[r][e] = 16'(r * 256 + e * 7 + 3);
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(busy, 0, "R1 busy"); chk(done, 0, "R1 done"); chk(mem_req, 0, "R1 mem_req");
    chk(vrf_we, 0, "R1 vrf_we"); chk(cfg_len, 0, "R1 cfg_len"); chk(cfg_stride, 0, "R1 cfg_stride");
    rst_n = 1;
    cycle();
    // R2 configuration writes, R3 invalid selectors
    cfg(3'd0, 6'd3);
    cfg(3'd1, 6'd5);
    cycle();
    chk(cfg_stride, 3, "R2 stride"); chk(cfg_len, 5, "R2 length");
    for (int s = 2; s < 8; s++) cfg(3'(s), 6'd41);
    cycle();
    chk(cfg_len, 5, "R3 length kept"); chk(cfg_stride, 3, "R3 stride kept");
    // R4 R5 R7 load with negative offset, R6 under backpressure
    always_rdy = 0;
    run_op(0, 3'd1, 16'h1000, 6'h3E);
    for (int i = 0; i < 5; i++)
      chk(vregs[1][i], (16'h0FFC + 6 * i) ^ 16'h5A3C, "R7 loaded element");
    chk(cfg_len, 5, "R12 length after load");
    // R8 store with wrap and maximum stride
    cfg(3'd0, 6'd63);
    run_op(1, 3'd1, 16'hFFF0, 6'h1F);
    // R10 zero length
    cfg(3'd1, 6'd0);
    seen_req = 0;
    op_start = 1; op_store = 0; op_vreg = 3'd2; op_base = 16'h0200; op_off = 0;
    cycle();
    op_start = 0;
    chk(done, 1, "R10 done pulse"); chk(busy, 0, "R10 busy low");
    cycle(); cycle();
    chk(seen_req, 0, "R10 no request");
    // R11 start while busy, R12 config write mid-operation
    cfg(3'd1, 6'd4); cfg(3'd0, 6'd1);
    op_start = 1; op_store = 0; op_vreg = 3'd3; op_base = 16'h4000; op_off = 6'd2;
    cycle();
    op_base = 16'h7000;
    cycle();
    op_start = 0;
    cfg(3'd1, 6'd9);
    for (int k = 0; k < 100 && (m_busy || m_done); k++) cycle();
    chk(vregs[3][0], 16'h4004 ^ 16'h5A3C, "R11 base kept");
    chk(vregs[3][3], 16'h400A ^ 16'h5A3C, "R12 count and stride kept");
    chk(vregs[3][4], 16'(3 * 256 + 4 * 7 + 3), "R12 no extra element");
    // full-length vector, always ready
    always_rdy = 1;
    cfg(3'd1, 6'd63); cfg(3'd0, 6'd2);
    run_op(0, 3'd7, 16'h8000, 6'h20);
    chk(vregs[7][62], (16'h7FC0 + 4 * 62) ^ 16'h5A3C, "R9 last of 63");
    repeat (4) cycle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule